// File: doc/BRIEF.md
# 16-bit Timer with Input Capture

A free-running 16-bit up-counter steps on a count-enable pulse. That pulse comes from one of four sources: a tick from a neighbouring timer, every system clock, every fourth system clock, or every thirty-second system clock. An input-capture path watches an external pin. On the edge or edges that the control register selects, it copies the counter into a 16-bit capture register.

When the counter wraps, it sets a sticky overflow flag. If inversion is enabled, the wrap also flips a timer output data bit that drives a single output pin. A separate enable bit decides whether that pin is driven or released.

Software reaches the block over a plain synchronous register bus. An 8-bit control register sits at address 0. The counter sits at address 1 and can be read or preloaded. The capture register sits at address 2 and is read-only.

Top module: `capture_timer16`

## Requirements
- R1: After reset the control register reads 0x00, the counter and capture register read 0x0000, and both the timer output and the output enable are low.
- R2: Control register (address 0) fields are: bit 0 output enable, bits 2:1 count-clock select, bit 3 inversion enable, bits 5:4 capture edge mode, bit 6 overflow flag, and bit 7 output data. A write stores bits 5:0 as written except bit 6. Bit 7 is read-only and is not affected by writes.
- R3: The count-clock select works as follows: 00 steps the counter once per cycle in which the external tick is high; 01 steps it every clock; 10 steps it once every 4 clocks; 11 steps it once every 32 clocks.
- R4: A bus write to address 1 loads the counter with the written 16-bit value. It takes priority over a count step in the same cycle. Writes to address 2 have no effect.
- R5: A count step at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (control bit 6) on the same clock edge.
- R6: The overflow flag is cleared only by a control write with bit 6 = 0. Writing 1 to bit 6 has no effect. A wrap in the same cycle as a clearing write leaves the flag set.
- R7: The capture pin passes through two synchronizing flops. Edge mode 00 never captures, 01 captures on rising edges, 10 on falling edges, and 11 on both. A qualifying pin edge loads the current counter value into the capture register within 3 clocks, exactly once.
- R8: While count-clock select is 01, no pin edge loads the capture register.
- R9: While inversion is enabled (bit 3 = 1), each counter wrap flips the output data bit. While inversion is disabled, the bit holds its value.
- R10: The timer output pin equals the output data bit (control bit 7), and the output enable pin equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 capture |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data (control uses bits 7:0) |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| ext_tick | input | 1 | Count pulse from another timer, synchronous to clk |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer output data |
| tmr_oe | output | 1 | Timer output enable (low = pin released) |

## Verification
The properties assume a few things about the inputs. The external tick and all bus signals are synchronous to the system clock. A bus write lasts exactly one cycle. The capture pin is low at reset, so the synchronizer starts without a false edge. The stimulus drives every input on the falling clock edge. It holds each capture-pin level for at least four cycles, so every edge clears the synchronizer before the next one arrives. Random phases freeze the counter on the external tick source, so each captured value is exactly the value last loaded or stepped.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int PS_W   = 5;
    localparam int MID_W  = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 2'd2;

    typedef enum logic [1:0] {
        CS_EXT   = 2'b00,
        CS_DIV1  = 2'b01,
        CS_DIV4  = 2'b10,
        CS_DIV32 = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        CM_OFF  = 2'b00,
        CM_RISE = 2'b01,
        CM_FALL = 2'b10,
        CM_BOTH = 2'b11
    } cap_mode_e;

    typedef struct packed {
        logic      out_data;
        logic      ovf;
        cap_mode_e cap_mode;
        logic      inv_en;
        clk_sel_e  clk_sel;
        logic      oe;
    } ctrl_t;

    function automatic logic edge_hit(cap_mode_e m, logic rise, logic fall);
        case (m)
            CM_RISE: edge_hit = rise;
            CM_FALL: edge_hit = fall;
            CM_BOTH: edge_hit = rise | fall;
            default: edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
    import tmr16_pkg::*;
#(
    parameter int DIV_W = PS_W,
    parameter int MID   = MID_W
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     ext_tick,
    output logic     step
);
    localparam logic [DIV_W-1:0] FULL = {DIV_W{1'b1}};
    localparam logic [MID-1:0]   MFULL = {MID{1'b1}};

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    always_comb begin
        case (sel)
            CS_EXT:   step = ext_tick;
            CS_DIV1:  step = 1'b1;
            CS_DIV4:  step = (div_q[MID-1:0] == MFULL);
            CS_DIV32: step = (div_q == FULL);
            default:  step = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    assign wrap = step && !ld && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (ld)   cnt <= ld_val;
        else if (step) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture
    import tmr16_pkg::*;
#(
    parameter int W      = 16,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    input  cap_mode_e    mode,
    input  logic         allow,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap
);
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              lvl, rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign lvl  = sync_q[SYNC_N-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_ff @(posedge clk) begin
        if (rst)                                    cap <= '0;
        else if (allow && edge_hit(mode, rise, fall)) cap <= cnt;
    end
endmodule

// File: rtl/capture_timer16.sv
module capture_timer16
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_tick,
    input  logic              cap_pin,
    output logic              tmr_out,
    output logic              tmr_oe
);
    ctrl_t            ctrl_q;
    logic             ctrl_wr, cnt_wr;
    logic             step, wrap;
    logic [CNT_W-1:0] cnt, cap;

    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
    assign cnt_wr  = bus_we && (bus_addr == A_CNT);

    tmr16_prescale #(.DIV_W(PS_W), .MID(MID_W)) u_ps (
        .clk(clk), .rst(rst), .sel(ctrl_q.clk_sel),
        .ext_tick(ext_tick), .step(step)
    );

    tmr16_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .step(step), .ld(cnt_wr),
        .ld_val(bus_wdata[CNT_W-1:0]), .cnt(cnt), .wrap(wrap)
    );

    tmr16_capture #(.W(CNT_W), .SYNC_N(2)) u_cap (
        .clk(clk), .rst(rst), .pin(cap_pin), .mode(ctrl_q.cap_mode),
        .allow(ctrl_q.clk_sel != CS_DIV1), .cnt(cnt), .cap(cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.cap_mode <= cap_mode_e'(bus_wdata[5:4]);
                ctrl_q.inv_en   <= bus_wdata[3];
                ctrl_q.clk_sel  <= clk_sel_e'(bus_wdata[2:1]);
                ctrl_q.oe       <= bus_wdata[0];
            end
            if (wrap)                         ctrl_q.ovf <= 1'b1;
            else if (ctrl_wr && !bus_wdata[6]) ctrl_q.ovf <= 1'b0;
            if (wrap && ctrl_q.inv_en)        ctrl_q.out_data <= ~ctrl_q.out_data;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
            A_CNT:   bus_rdata = cnt;
            A_CAP:   bus_rdata = cap;
            default: bus_rdata = '0;
        endcase
    end

    assign tmr_out = ctrl_q.out_data;
    assign tmr_oe  = ctrl_q.oe;
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker (
    input logic        clk,
    input logic        rst,
    input logic        cnt_wr,
    input logic        ctrl_wr,
    input logic        wbit6,
    input logic [15:0] cnt,
    input logic [15:0] cap,
    input logic [7:0]  ctrl,
    input logic        tmr_out
);
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 16'd1));

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt == 16'hFFFF && !cnt_wr) |=> (cnt == 16'hFFFF || cnt == 16'h0000));

    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt) == 16'hFFFF && cnt == 16'h0000 && !$past(cnt_wr)) |-> ctrl[6]);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl[6] && !(ctrl_wr && !wbit6)) |=> ctrl[6]);

    a_r8_no_cap_fast: assert property (@(posedge clk) disable iff (rst)
        (ctrl[2:1] == 2'b01) |=> $stable(cap));

    a_r9_hold_out: assert property (@(posedge clk) disable iff (rst)
        !ctrl[3] |=> $stable(tmr_out));
endmodule

bind capture_timer16 tmr16_checker u_chk (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
    .wbit6(bus_wdata[6]), .cnt(cnt), .cap(cap), .ctrl(ctrl_q),
    .tmr_out(tmr_out)
);

// File: tb/capture_timer16_test.sv
`timescale 1ns/1ps
module capture_timer16_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        cap_pin = 1'b0;
    logic        tmr_out, tmr_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    capture_timer16 uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_tick(ext_tick),
        .cap_pin(cap_pin), .tmr_out(tmr_out), .tmr_oe(tmr_oe)
    );

    function automatic logic [7:0] ctrl_word(logic [1:0] cm, logic inv,
                                             logic [1:0] cs, logic oe, logic w6);
        return {1'b0, w6, cm, inv, cs, oe};
    endfunction

    function automatic logic hit(logic [1:0] cm, logic rising);
        return (cm == 2'b11) || (cm == 2'b01 && rising) || (cm == 2'b10 && !rising);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic tick_pulse();
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    task automatic rate(string req, logic [1:0] cs, int expd);
        logic [15:0] c0, c1;
        wr(2'd0, 16'(ctrl_word(2'b00, 1'b0, cs, 1'b0, 1'b0)));
        rd(2'd1, c0);
        repeat (32) @(negedge clk);
        rd(2'd1, c1);
        check(req, c1 - c0, 16'(expd));
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, exp_cap, exp_cnt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
        rd(2'd1, v); check("R1 counter", v, 16'h0000);
        rd(2'd2, v); check("R1 capture", v, 16'h0000);
        check("R1 pins", {14'd0, tmr_out, tmr_oe}, 16'h0);

        // R2 field storage, bit 7 read-only, bit 6 write-1 ignored
        wr(2'd0, 16'h00FF);
        rd(2'd0, v); check("R2 fields", v, 16'h003F);
        // R10 oe follows bit 0
        check("R10 oe high", {15'd0, tmr_oe}, 16'd1);
        wr(2'd0, 16'h0000);
        check("R10 oe low", {15'd0, tmr_oe}, 16'd0);

        // R3 rates
        rate("R3 div1", 2'b01, 32);
        rate("R3 div4", 2'b10, 8);
        rate("R3 div32", 2'b11, 1);
        rate("R3 ext idle", 2'b00, 0);

        // R4 load priority under div1
        wr(2'd0, 16'(ctrl_word(2'b00, 1'b0, 2'b01, 1'b0, 1'b0)));
        wr(2'd1, 16'hABCD);
        rd(2'd1, v); check("R4 load", v, 16'hABCD);
        wr(2'd0, 16'h0000);
        rd(2'd2, exp_cap);
        wr(2'd2, 16'h5555);
        rd(2'd2, v); check("R4 capture write ignored", v, exp_cap);

        // R8: capture blocked on div1
        wr(2'd0, 16'(ctrl_word(2'b11, 1'b0, 2'b01, 1'b0, 1'b0)));
        cap_pin = 1'b1; repeat (5) @(negedge clk);
        cap_pin = 1'b0; repeat (5) @(negedge clk);
        rd(2'd2, v); check("R8 no capture on div1", v, exp_cap);

        // R7 random capture and R3 ext tick counting
        for (int i = 0; i < 24; i++) begin
            logic [1:0] cm;
            int nt;
            cm = 2'($urandom);
            wr(2'd0, 16'(ctrl_word(cm, 1'b0, 2'b00, 1'b0, 1'b0)));
            exp_cnt = 16'($urandom);
            wr(2'd1, exp_cnt);
            cap_pin = ~cap_pin;
            if (hit(cm, cap_pin)) exp_cap = exp_cnt;
            repeat (4) @(negedge clk);
            rd(2'd2, v); check("R7 capture mode", v, exp_cap);
            nt = int'($urandom % 8);
            for (int k = 0; k < nt; k++) begin
                tick_pulse();
                @(negedge clk);
            end
            exp_cnt = exp_cnt + 16'(nt);
            rd(2'd1, v); check("R3 ext tick count", v, exp_cnt);
        end

        // R5 wrap and flag, R9 inversion toggles output, R10 pin
        wr(2'd0, 16'(ctrl_word(2'b00, 1'b1, 2'b00, 1'b1, 1'b0)));
        wr(2'd1, 16'hFFFF);
        tick_pulse();
        rd(2'd1, v); check("R5 wrap to zero", v, 16'h0000);
        rd(2'd0, v); check("R5 flag and R9 toggle", v & 16'h00C0, 16'h00C0);
        check("R10 out pin", {15'd0, tmr_out}, 16'd1);

        // R6 write 1 does not clear; write 0 clears; bit7 stays
        wr(2'd0, 16'(ctrl_word(2'b00, 1'b1, 2'b00, 1'b1, 1'b1)));
        rd(2'd0, v); check("R6 write one keeps flag", v & 16'h0040, 16'h0040);
        wr(2'd0, 16'(ctrl_word(2'b00, 1'b1, 2'b00, 1'b1, 1'b0)));
        rd(2'd0, v); check("R6 clear", v & 16'h00C0, 16'h0080);

        // R6 set beats clear in the same cycle
        wr(2'd1, 16'hFFFF);
        ext_tick = 1'b1;
        wr(2'd0, 16'(ctrl_word(2'b00, 1'b1, 2'b00, 1'b1, 1'b0)));
        ext_tick = 1'b0;
        rd(2'd0, v); check("R6 set wins", v & 16'h0040, 16'h0040);
        check("R9 second toggle", {15'd0, tmr_out}, 16'd0);

        // R9 hold with inversion disabled
        wr(2'd0, 16'(ctrl_word(2'b00, 1'b0, 2'b00, 1'b1, 1'b0)));
        wr(2'd1, 16'hFFFF);
        tick_pulse();
        check("R9 hold when disabled", {15'd0, tmr_out}, 16'd0);
        rd(2'd0, v); check("R5 flag again", v & 16'h0040, 16'h0040);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule